// File: doc/BRIEF.md
# Fractional Multiply-Accumulate-Round Unit

This block is a single-issue datapath for fractional arithmetic. Each accepted operation multiplies two signed 16-bit fractional operands, which yields a product scaled by two relative to the integer product. It adds that product to a 36-bit addend or subtracts it from the addend. It then rounds the sum to the high word and clears the low word. The 36-bit addend has 4 guard bits above a 32-bit value. It is either an accumulator value supplied whole or a 16-bit register value widened to 36 bits.

A strobe qualifies each operation, and the result appears one clock later with its own valid flag. A mode bit selects the rounding: convergent rounding (ties go to the even high word) or plain two's-complement rounding (ties go upward). The full 36-bit result serves accumulator destinations. A separate 16-bit word output carries the rounded high word for register destinations. Saturation, operand selection and instruction decode belong to the surrounding logic.

Top module: `frac_macr`

## Requirements
- R1: The product is the signed product of `op_a` and `op_b`, shifted left by one bit and sign-extended to 36 bits before it is combined with the addend.
- R2: When `do_sub` is 0 the product is added to the addend. When `do_sub` is 1 the product is subtracted from the addend.
- R3: When `dst_is_reg` is 1 the addend is `reg_in` sign-extended by 4 bits with 16 zero bits appended below it, and `acc_in` has no effect. When `dst_is_reg` is 0 the addend is `acc_in`.
- R4: With `rnd_twos` = 1, rounding adds 0x8000 to the low word of the sum, carries into bits 35:16, and clears the low word.
- R5: With `rnd_twos` = 0, rounding is the same as R4 except when the low word equals exactly 0x8000. In that case bits 35:16 are incremented only if bit 16 of the sum is 1.
- R6: Bits 15:0 of `acc_out` are zero after every operation.
- R7: 0x8000 times 0x8000 gives the product 0x0_8000_0000, which is kept without saturation. Added to a zero addend it yields `acc_out` 0x0_8000_0000.
- R8: `word_out` equals bits 31:16 of the rounded result.
- R9: The results and `out_valid` register on the clock edge that samples `in_valid` high. While `in_valid` is low, `out_valid` is 0 and the result outputs hold.
- R10: While `rst_n` is low, `out_valid`, `acc_out` and `word_out` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| in_valid | input | 1 | Operation strobe |
| op_a | input | 16 | Fractional multiplier operand |
| op_b | input | 16 | Fractional multiplier operand |
| acc_in | input | 36 | Accumulator addend (guard:high:low) |
| reg_in | input | 16 | Register-destination addend |
| dst_is_reg | input | 1 | 1 selects the register addend |
| do_sub | input | 1 | 1 subtracts the product |
| rnd_twos | input | 1 | 1 two's-complement rounding, 0 convergent |
| out_valid | output | 1 | Result valid, one cycle after the strobe |
| acc_out | output | 36 | Rounded 36-bit result, low word zero |
| word_out | output | 16 | Rounded high word |

## Verification
The bench targets the exact half-way low word 0x8000 under both rounding modes and with both parities of bit 16. A unit that ignored the mode, or rounded ties the wrong way, returns a high word that is off by one. The 0x8000 times 0x8000 case exposes a design that keeps the shifted product at only 32 bits, because its result turns negative. Negative register values show whether the guard bits receive a proper sign extension. Idle cycles with changing inputs catch results that update without the strobe.

// File: rtl/frac_macr.sv
module frac_macr #(
  parameter int W = 16,
  parameter int G = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [W-1:0]      op_a,
  input  logic [W-1:0]      op_b,
  input  logic [G+2*W-1:0]  acc_in,
  input  logic [W-1:0]      reg_in,
  input  logic              dst_is_reg,
  input  logic              do_sub,
  input  logic              rnd_twos,
  output logic              out_valid,
  output logic [G+2*W-1:0]  acc_out,
  output logic [W-1:0]      word_out
);
  localparam int AW = G + 2*W;
  localparam int HW = G + W;

  logic signed [2*W-1:0] prod;
  logic [AW-1:0] prod_x, addend, sum;
  logic [HW-1:0] upper, up_rnd;
  logic [W-1:0]  lo;
  logic          tie, inc;

  assign prod   = $signed(op_a) * $signed(op_b);
  assign prod_x = {{G{prod[2*W-1]}}, prod} << 1;
  assign addend = dst_is_reg ? {{G{reg_in[W-1]}}, reg_in, {W{1'b0}}} : acc_in;
  assign sum    = do_sub ? addend - prod_x : addend + prod_x;

  assign lo     = sum[W-1:0];
  assign upper  = sum[AW-1:W];
  assign tie    = (lo == {1'b1, {(W-1){1'b0}}});
  assign inc    = (!rnd_twos && tie) ? upper[0] : lo[W-1];
  assign up_rnd = upper + {{(HW-1){1'b0}}, inc};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      acc_out   <= '0;
      word_out  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        acc_out  <= {up_rnd, {W{1'b0}}};
        word_out <= up_rnd[W-1:0];
      end
    end
  end

  p_valid_follow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(acc_out) && $stable(word_out)));
  p_zero_prod_acc_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !dst_is_reg && op_a == '0 &&
     (rnd_twos || acc_in[W-1:0] != {1'b1, {(W-1){1'b0}}}))
    |=> acc_out[AW-1:W] == $past(acc_in[AW-1:W]) + {{(HW-1){1'b0}}, $past(acc_in[W-1])});
  p_zero_prod_reg_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && dst_is_reg && op_b == '0) |=> word_out == $past(reg_in));
  p_low_word_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> acc_out[W-1:0] == '0);
endmodule

// File: tb/frac_macr_test.sv
`timescale 1ns/1ps
module frac_macr_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [15:0] op_a = '0, op_b = '0, reg_in = '0;
  logic [35:0] acc_in = '0;
  logic dst_is_reg = 1'b0, do_sub = 1'b0, rnd_twos = 1'b0;
  logic out_valid;
  logic [35:0] acc_out;
  logic [15:0] word_out;

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  frac_macr uut (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
    .acc_in(acc_in), .reg_in(reg_in), .dst_is_reg(dst_is_reg), .do_sub(do_sub),
    .rnd_twos(rnd_twos), .out_valid(out_valid), .acc_out(acc_out), .word_out(word_out));

  // a, b, acc, reg, is_reg, sub, twos
  localparam int NV = 12;
  localparam logic [86:0] VEC [0:NV-1] = '{
    {16'h4000, 16'hC000, 36'h0_0003_8000, 16'h0000, 1'b0, 1'b1, 1'b0},
    {16'h4000, 16'hC000, 36'h0_0003_8000, 16'h0000, 1'b0, 1'b1, 1'b1},
    {16'h1234, 16'h5678, 36'h0_0000_0000, 16'h0000, 1'b0, 1'b0, 1'b0},
    {16'h8000, 16'h7FFF, 36'h0_1111_7FFF, 16'h0000, 1'b0, 1'b0, 1'b1},
    {16'hFFFF, 16'hFFFF, 36'hF_FFFF_8000, 16'h0000, 1'b0, 1'b1, 1'b0},
    {16'h7FFF, 16'h7FFF, 36'h7_FFFF_FFFF, 16'h0000, 1'b0, 1'b0, 1'b0},
    {16'hA5A5, 16'h5A5A, 36'h8_0000_0000, 16'h0000, 1'b0, 1'b1, 1'b1},
    {16'h0001, 16'h0001, 36'h0_0004_7FFF, 16'h0000, 1'b0, 1'b0, 1'b0},
    {16'h4000, 16'h4000, 36'h0_0000_0000, 16'h1234, 1'b1, 1'b0, 1'b0},
    {16'h4000, 16'h4000, 36'hF_FFFF_FFFF, 16'h8000, 1'b1, 1'b1, 1'b1},
    {16'h0001, 16'h4000, 36'h0_0000_0000, 16'h0005, 1'b1, 1'b0, 1'b0},
    {16'hC000, 16'h0001, 36'h0_0000_0000, 16'hFFFE, 1'b1, 1'b1, 1'b0}
  };

  function automatic logic [35:0] model(input logic [15:0] a, input logic [15:0] b,
      input logic [35:0] acc, input logic [15:0] rg, input bit isr, input bit sb, input bit tw);
    longint p, ad, s, hi, lw;
    p  = longint'($signed(a)) * longint'($signed(b)) * 2;
    ad = isr ? longint'($signed(rg)) * 65536 : longint'($signed({{28{acc[35]}}, acc}));
    s  = sb ? ad - p : ad + p;
    lw = s & 64'hFFFF;
    hi = s >>> 16;
    if (lw > 32768) hi = hi + 1;
    else if (lw == 32768) hi = hi + (tw ? 1 : (hi & 1));
    return 36'(hi << 16);
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [86:0] v);
    @(negedge clk);
    {op_a, op_b, acc_in, reg_in, dst_is_reg, do_sub, rnd_twos} = v;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic run_exp(input logic [86:0] v, input string req, input logic [35:0] exp);
    issue(v);
    check(req, {63'd0, out_valid}, 64'd1);
    check(req, {28'd0, acc_out}, {28'd0, exp});
    check("R8", {48'd0, word_out}, {48'd0, exp[31:16]});
    check("R6", {48'd0, acc_out[15:0]}, 64'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R10", {63'd0, out_valid}, 64'd0);
    check("R10", {28'd0, acc_out}, 64'd0);
    check("R10", {48'd0, word_out}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9", {63'd0, out_valid}, 64'd0);

    for (int i = 0; i < NV; i++) begin
      logic [86:0] v;
      v = VEC[i];
      run_exp(v, "R1 R2 R4 R5 vector",
        model(v[86:71], v[70:55], v[54:19], v[18:3], v[2], v[1], v[0]));
    end

    run_exp({16'h4000, 16'hC000, 36'h0_0003_8000, 16'h0, 1'b0, 1'b1, 1'b0}, "R2 R5 sub", 36'h0_2004_0000);
    run_exp({16'h8000, 16'h8000, 36'h0, 16'h0, 1'b0, 1'b0, 1'b0}, "R7 min*min", 36'h0_8000_0000);
    run_exp({16'h0000, 16'h0000, 36'h0_0002_8000, 16'h0, 1'b0, 1'b0, 1'b0}, "R5 tie even", 36'h0_0002_0000);
    run_exp({16'h0000, 16'h0000, 36'h0_0002_8000, 16'h0, 1'b0, 1'b0, 1'b1}, "R4 tie up", 36'h0_0003_0000);
    run_exp({16'h0000, 16'h0000, 36'h0_0003_8000, 16'h0, 1'b0, 1'b0, 1'b0}, "R5 tie odd", 36'h0_0004_0000);
    run_exp({16'h0000, 16'h0000, 36'h0_0003_7FFF, 16'h0, 1'b0, 1'b0, 1'b1}, "R4 below half", 36'h0_0003_0000);
    run_exp({16'h4000, 16'h4000, 36'h0_7777_7777, 16'h1234, 1'b1, 1'b0, 1'b0}, "R3 reg add", 36'h0_3234_0000);
    run_exp({16'h4000, 16'h4000, 36'h0_0000_0000, 16'h8000, 1'b1, 1'b1, 1'b0}, "R3 reg sext", 36'hF_6000_0000);
    run_exp({16'h0001, 16'h0001, 36'h0_0000_0000, 16'h0000, 1'b0, 1'b1, 1'b1}, "R1 tiny sub", 36'h0);

    // R9: idle cycles with changing inputs leave the result untouched
    @(negedge clk);
    op_a = 16'h7FFF; op_b = 16'h7FFF; acc_in = 36'h1_2345_6789; do_sub = 1'b0;
    @(negedge clk);
    check("R9 idle valid", {63'd0, out_valid}, 64'd0);
    check("R9 idle hold", {28'd0, acc_out}, 64'd0);
    check("R9 idle word", {48'd0, word_out}, 64'd0);

    // R10: reset mid-stream clears outputs
    run_exp({16'h4000, 16'h4000, 36'h0, 16'h0, 1'b0, 1'b0, 1'b0}, "R1 pre-reset", 36'h0_2000_0000);
    rst_n = 1'b0;
    @(negedge clk);
    check("R10 reset acc", {28'd0, acc_out}, 64'd0);
    check("R10 reset valid", {63'd0, out_valid}, 64'd0);

    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule